// File: doc/BRIEF.md
# Paged Address Translation Mapper

This block turns a 16-bit CPU address into a 20-bit physical SRAM address. Each of the sixteen 4 KB pages of the CPU space has its own 8-bit translation register. The register's value becomes the upper bits of the physical address, and the low 12 CPU address bits pass through unchanged. The range $E000-$E1FF is left to I/O and is never sent to SRAM.

A configuration register can switch on read-only overlays:

- When the low overlay is on, pages C and D read through alternate registers and refuse writes.
- When the high overlay is on, $E200-$FFFF reads through alternate registers and refuses writes.
- The alternate registers come in two banks. A bank-select bit picks between them, and that bit loads from a strap pin at reset.
- With the high overlay on and write-redirect enabled, a CPU write to $FFF0-$FFFF loads page register 0-F (chosen by the low address nibble) instead of memory.
- A boot overlay sends reads of $F000-$FFFF to an internal boot ROM and blocks writes there. It overrides every other overlay.

An external I/O decoder asserts one of three selects to reach the page registers, the alternate registers and the configuration register. The CPU low address bits index the register and the CPU write strobe and data do the writing. The block itself performs no SRAM timing.

Top module: `page_mapper`

## Requirements
- R1: After reset, page register n holds n, giving an identity mapping. Alternate register i holds 12 + (i mod 4), where i is 0-7 in the order C0,D0,E0,F0,C1,D1,E1,F1. The configuration register reads `strap_bank` at bit 3 and 0 elsewhere.
- R2: With no overlay active, phys_addr = {page[cpu_addr[15:12]], cpu_addr[11:0]} and sram_sel is 1. A write (cpu_wr=1) there leaves wr_block at 0.
- R3: For cpu_addr in $E000-$E1FF: sram_sel, boot_sel and wr_block are all 0.
- R4: When sel_page=1, a write stores cpu_wdata into page register cpu_addr[3:0], and rd_data returns that register. With no select asserted, rd_data is 0.
- R5: When sel_alt=1, cpu_addr[2:0] indexes the alternate registers in the order C0,D0,E0,F0,C1,D1,E1,F1, for both writing and reading.
- R6: When sel_cfg=1, the configuration register is accessed. Its fields are: bit 7 = write-redirect enable, bit 6 = boot overlay, bit 3 = bank, bit 2 = high overlay, bit 1 = low overlay. Bits 5, 4 and 0 read 0.
- R7: With the low overlay on, $C000-$DFFF translates through alternate register {bank, page[1:0]}, and a write there gives wr_block=1. With the low overlay off, pages C and D use their normal registers.
- R8: With the high overlay on, $E200-$FFFF translates through alternate register {bank, page[1:0]}, and a write to $E200-$FFEF gives wr_block=1.
- R9: With the high overlay and write-redirect both on (and the boot overlay off), a write to $FFF0-$FFFF loads page register cpu_addr[3:0] and gives wr_block=1. With write-redirect off, the write is blocked and no page register changes.
- R10: With the boot overlay on, $F000-$FFFF gives boot_sel=1 and sram_sel=0. Writes there give wr_block=1 and never redirect into a page register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_bank | input | 1 | Bank-select value loaded at reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| sel_page | input | 1 | Page-register window select |
| sel_alt | input | 1 | Alternate-register window select |
| sel_cfg | input | 1 | Configuration register select |
| rd_data | output | 8 | Register read data |
| phys_addr | output | 20 | Translated physical address |
| sram_sel | output | 1 | Access goes to SRAM |
| boot_sel | output | 1 | Access goes to boot ROM |
| wr_block | output | 1 | Memory write suppressed |

## Verification
The translation is exercised with three kinds of page register contents, each of which separates a different fault:

- Identity contents after reset show that the page index is not swapped or shifted.
- Distinct non-identity values show that the correct register is picked.
- Alternate registers loaded with a unique marker per index (0x80+i) show whether a read used the normal or the alternate register, which bank was used, and which page slot.

Probes land on both sides of each region edge ($E1FF/$E200, $FFEF/$FFF0, $C000/$E000). Every overlay combination is tried with and without a write, which separates read mapping from write blocking. Redirected writes are checked by reading the page registers back. Blocked writes are checked the same way.

// File: rtl/page_mapper.sv
module page_mapper #(
  parameter int PAGE_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 strap_bank,
  input  logic [15:0]          cpu_addr,
  input  logic                 cpu_wr,
  input  logic [7:0]           cpu_wdata,
  input  logic                 sel_page,
  input  logic                 sel_alt,
  input  logic                 sel_cfg,
  output logic [7:0]           rd_data,
  output logic [PAGE_W+11:0]   phys_addr,
  output logic                 sram_sel,
  output logic                 boot_sel,
  output logic                 wr_block
);
  localparam int NPAGE = 16;
  localparam int NALT  = 8;
  localparam logic [7:0] CFG_MASK = 8'hCE;

  logic [NPAGE-1:0][PAGE_W-1:0] page_q;
  logic [NALT-1:0][PAGE_W-1:0]  alt_q;
  logic [7:0]                   cfg_q;

  logic [3:0] pg;
  logic wodat, bootrom, bank, romseh, romsel;
  logic io_hit, boot_hit, lo_ov, hi_ov, redirect;
  logic [PAGE_W-1:0] xlat;

  assign pg      = cpu_addr[15:12];
  assign wodat   = cfg_q[7];
  assign bootrom = cfg_q[6];
  assign bank    = cfg_q[3];
  assign romseh  = cfg_q[2];
  assign romsel  = cfg_q[1];

  assign io_hit   = cpu_addr[15:9] == 7'b1110_000;
  assign boot_hit = bootrom && pg == 4'hF;
  assign lo_ov    = romsel && pg[3:1] == 3'b110;
  assign hi_ov    = romseh && pg[3:1] == 3'b111 && !io_hit;
  assign redirect = romseh && wodat && !boot_hit && cpu_addr[15:4] == 12'hFFF;

  assign xlat      = (lo_ov || hi_ov) ? alt_q[{bank, pg[1:0]}] : page_q[pg];
  assign phys_addr = {xlat, cpu_addr[11:0]};
  assign sram_sel  = !io_hit && !boot_hit;
  assign boot_sel  = boot_hit;
  assign wr_block  = cpu_wr && (boot_hit || lo_ov || hi_ov);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPAGE; i++) page_q[i] <= PAGE_W'(i);
      for (int i = 0; i < NALT; i++)  alt_q[i]  <= PAGE_W'(12 + (i % 4));
      cfg_q <= {4'b0000, strap_bank, 3'b000};
    end else begin
      if (cpu_wr && (sel_page || redirect)) page_q[cpu_addr[3:0]] <= PAGE_W'(cpu_wdata);
      if (cpu_wr && sel_alt) alt_q[cpu_addr[2:0]] <= PAGE_W'(cpu_wdata);
      if (cpu_wr && sel_cfg) cfg_q <= cpu_wdata & CFG_MASK;
    end
  end

  always_comb begin
    if (sel_page)      rd_data = 8'(page_q[cpu_addr[3:0]]);
    else if (sel_alt)  rd_data = 8'(alt_q[cpu_addr[2:0]]);
    else if (sel_cfg)  rd_data = cfg_q;
    else               rd_data = 8'h00;
  end

  // R3
  io_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr[15:9] == 7'h70 |-> !sram_sel && !boot_sel && !wr_block);

  // R10
  boot_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot_sel |-> !sram_sel && (!cpu_wr || wr_block));

  // R9
  redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && redirect |=> page_q[$past(cpu_addr[3:0])] == PAGE_W'($past(cpu_wdata)));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_wr |=> $stable(page_q) && $stable(alt_q) && $stable(cfg_q));

  // R6
  cfg_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~CFG_MASK) == 8'h00 || !sel_cfg || sel_page || sel_alt);

  // R7
  lo_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && cfg_q[1] && cpu_addr[15:13] == 3'b110 |-> wr_block);
endmodule

// File: tb/page_mapper_test.sv
module page_mapper_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_bank = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic        sel_page = 1'b0, sel_alt = 1'b0, sel_cfg = 1'b0;
  logic [7:0]  rd_data;
  logic [19:0] phys_addr;
  logic        sram_sel, boot_sel, wr_block;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  page_mapper uut (.*);

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired (all requirements) actual %0d expected <20000 cycles", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    cpu_wr = 0; sel_page = 0; sel_alt = 0; sel_cfg = 0; cpu_wdata = '0;
  endtask

  task automatic reg_write(input int kind, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1;
    sel_page = (kind == 0); sel_alt = (kind == 1); sel_cfg = (kind == 2);
    @(posedge clk); #1 idle();
  endtask

  task automatic reg_read(input int kind, input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wr = 0;
    sel_page = (kind == 0); sel_alt = (kind == 1); sel_cfg = (kind == 2);
    #1 d = rd_data;
    idle();
  endtask

  task automatic probe(input logic [15:0] a, input logic wr, input string req,
                       input logic [19:0] exp_pa, input logic [2:0] exp_flags);
    @(negedge clk);
    cpu_addr = a; cpu_wr = wr; cpu_wdata = 8'hEE;
    #1;
    check({req, " phys"}, phys_addr, exp_pa);
    check({req, " sram/boot/blk"}, {sram_sel, boot_sel, wr_block}, exp_flags);
    cpu_wr = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int i = 0; i < 16; i++) begin
      reg_read(0, 16'hE070 + 16'(i), d);
      check("R1 page reset", d, 8'(i));
    end
    for (int i = 0; i < 8; i++) begin
      reg_read(1, 16'hE080 + 16'(i), d);
      check("R1/R5 alt reset", d, 8'(12 + i % 4));
    end
    reg_read(2, 16'hE040, d);
    check("R1 cfg reset", d, 8'h08);
    reg_read(3, 16'h0000, d);
    check("R4 no select reads 0", d, 8'h00);
    probe(16'h3ABC, 0, "R1 identity", 20'h03ABC, 3'b100);
  endtask

  task automatic t_normal();
    logic [7:0] d;
    reg_write(0, 16'hE073, 8'hA5);
    reg_write(0, 16'hE07C, 8'h5A);
    reg_read(0, 16'hE073, d);
    check("R4 page readback", d, 8'hA5);
    probe(16'h3123, 1, "R2 page3", 20'hA5123, 3'b100);
    probe(16'hC7FF, 1, "R2/R7 pageC no overlay", 20'h5A7FF, 3'b100);
    probe(16'hFFF2, 1, "R2 top no overlay", 20'h0FFF2, 3'b100);
    reg_read(0, 16'hE072, d);
    check("R2 plain write no redirect", d, 8'h02);
  endtask

  task automatic t_io();
    probe(16'hE000, 1, "R3 io low", 20'h0E000, 3'b000);
    probe(16'hE1FF, 1, "R3 io high", 20'h0E1FF, 3'b000);
    probe(16'hE200, 1, "R3 above io", 20'h0E200, 3'b100);
  endtask

  task automatic t_alt_low();
    logic [7:0] d;
    for (int i = 0; i < 8; i++) reg_write(1, 16'hE080 + 16'(i), 8'h80 + 8'(i));
    for (int i = 0; i < 8; i++) begin
      reg_read(1, 16'hE088 + 16'(i), d);
      check("R5 alt readback", d, 8'h80 + 8'(i));
    end
    reg_write(2, 16'hE040, 8'h0A);
    probe(16'hC010, 1, "R7 C bank1", 20'h84010, 3'b101);
    probe(16'hDFFF, 0, "R7 D bank1", 20'h85FFF, 3'b100);
    probe(16'hE300, 1, "R7 E unaffected", 20'h0E300, 3'b100);
    reg_write(2, 16'hE040, 8'h02);
    probe(16'hC010, 0, "R7 C bank0", 20'h80010, 3'b100);
    probe(16'hB000, 1, "R7 B unaffected", 20'h0B000, 3'b100);
  endtask

  task automatic t_alt_high();
    reg_write(2, 16'hE040, 8'h04);
    probe(16'hE300, 1, "R8 E0", 20'h82300, 3'b101);
    probe(16'hE1FF, 1, "R8/R3 io kept", 20'h0E1FF, 3'b000);
    probe(16'hF800, 0, "R8 F0", 20'h83800, 3'b100);
    probe(16'hC000, 1, "R8 C unaffected", 20'h5A000, 3'b100);
    reg_write(2, 16'hE040, 8'h0C);
    probe(16'hF800, 0, "R8 F1", 20'h87800, 3'b100);
    probe(16'hFFEF, 1, "R8 FFEF blocked", 20'h87FEF, 3'b101);
  endtask

  task automatic t_redirect();
    logic [7:0] d;
    reg_write(2, 16'hE040, 8'h84);
    probe(16'hFFF5, 1, "R9 redirect blocks mem", 20'h83FF5, 3'b101);
    reg_write(3, 16'hFFF5, 8'h3C);
    reg_read(0, 16'hE075, d);
    check("R9 redirect loads page5", d, 8'h3C);
    reg_write(2, 16'hE040, 8'h04);
    reg_write(3, 16'hFFF6, 8'h77);
    reg_read(0, 16'hE076, d);
    check("R9 no redirect without enable", d, 8'h06);
  endtask

  task automatic t_boot();
    logic [7:0] d;
    reg_write(2, 16'hE040, 8'hC4);
    probe(16'hF123, 0, "R10 boot read", 20'h83123, 3'b010);
    probe(16'hFFF7, 1, "R10 boot write", 20'h83FF7, 3'b011);
    reg_write(3, 16'hFFF7, 8'h55);
    reg_read(0, 16'hE077, d);
    check("R10 no redirect under boot", d, 8'h07);
    probe(16'hE300, 0, "R10 E still overlay", 20'h82300, 3'b100);
    reg_write(2, 16'hE040, 8'hFF);
    reg_read(2, 16'hE040, d);
    check("R6 cfg mask", d, 8'hCE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_normal();
    t_io();
    t_alt_low();
    t_alt_high();
    t_redirect();
    t_boot();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule